// File: doc/BRIEF.md
# Configurable-Order Delta-Sigma DAC Modulator

This block turns a stream of signed audio samples into a fast, coarse output code. An external low-pass filter averages that code back into an analog waveform. The loop advances once on every system clock, for example at 50 MHz. That rate sits far above the audio sample rate, so a sample source with a strobe supplies new samples only now and then. The block holds the most recent sample between strobes.

Two parameters select the loop:

- `ORDER` sets one or two integrators.
- `QBITS` sets the quantizer. A value of 1 gives a sign decision with output levels ±1. A larger value gives a rounding quantizer with two's-complement levels.

The usual pairings are a first-order loop with a 1-bit output and a second-order loop with a 4-bit output.

Each quantizer level is worth S = 2^(SAMPLE_W−QBITS) input units. This makes the ±1 levels of the 1-bit mode full scale. The previous cycle's registered level is fed back into every integrator. The integrators carry headroom bits and clip at their limits instead of wrapping.

Top module: `dsm_modulator`

## Requirements
- R1: On a clock edge with `smp_vld` high, `smp_in` is captured. The loop uses the held value from the next cycle on. While `smp_vld` is low, `smp_in` has no effect on `dac_code`.
- R2: A synchronous `rst` clears the held sample, every integrator and the feedback level to zero. While in reset, `dac_code` reads 0.
- R3: With ORDER=1 and QBITS=1, the integrator adds x − q·2^(SAMPLE_W−1) each cycle. The new level q is +1 when the updated integrator is greater than 0, otherwise −1. `dac_code` is 1 for +1 and 0 for −1, so a zero input after reset gives 0,1,0,1,...
- R4: With ORDER=2, the first integrator adds x − q·S. The second integrator adds the updated first integrator minus q·S. Here q is the registered level from the previous cycle.
- R5: With QBITS>1, the new level is floor((i2 + S/2)/S), where i2 is the updated last integrator. `dac_code` carries this level in two's complement. The default S is 4096.
- R6: The multi-bit level is clamped to −2^(QBITS−1) .. 2^(QBITS−1)−1 (−8..+7 by default). A large input therefore settles at the end code and never wraps to the opposite sign.
- R7: Each integrator saturates at −2^(SAMPLE_W+HEADROOM−1) and 2^(SAMPLE_W+HEADROOM−1)−1 (−524288..524287 by default) rather than wrapping.
- R8: For a constant held sample x inside the stable range, the mean of q·S over 1024 consecutive cycles lies within 128 of x, in both loop variants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one loop update per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Strobe: capture `smp_in` on this edge |
| smp_in | input | SAMPLE_W | Signed input sample |
| dac_code | output | QBITS | Output code: sign bit (QBITS=1) or two's-complement level |

## Verification
The embedded assertions check the following every cycle:

- the sample register loads on a strobe and stays stable without one;
- a reset clears the integrators and the feedback;
- an integrator sitting at a limit stays there while pushed outward;
- the registered level follows the sign or clamp rule for the integrator value it was computed from.

Some properties appear only over whole runs, so only the bench scenarios can show them. These are the exact integrator arithmetic, the rounding ties, the recovery after deep saturation, and the average tracking of each held sample. The bench compares both loop variants cycle by cycle against an independent arithmetic model and also checks the long-run mean directly.

// File: rtl/dsm_hold.sv
module dsm_hold #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vld,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] held
);

    always_ff @(posedge clk) begin
        if (rst)      held <= '0;
        else if (vld) held <= din;
    end

    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (rst)
        vld |=> (held == $past(din)));  // R1
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(held));  // R1

endmodule

// File: rtl/dsm_integ.sv
module dsm_integ #(
    parameter int ACC_W = 20,
    parameter int DW    = 22
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [DW-1:0]    delta,
    output logic signed [ACC_W-1:0] acc_nx
);

    localparam int SW = DW + 1;
    localparam logic signed [ACC_W-1:0] TOP = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] BOT = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W-1:0] acc_q;
    logic signed [SW-1:0]    sum;

    assign sum = SW'(acc_q) + SW'(delta);

    always_comb begin
        if (sum > SW'(TOP))      acc_nx = TOP;
        else if (sum < SW'(BOT)) acc_nx = BOT;
        else                     acc_nx = ACC_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_nx;
    end

    AST_INT_CLEAR: assert property (@(posedge clk)
        rst |=> (acc_q == '0));  // R2
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
        (acc_q == TOP && delta >= 0) |=> (acc_q == TOP));  // R7
    AST_SAT_BOT: assert property (@(posedge clk) disable iff (rst)
        (acc_q == BOT && delta <= 0) |=> (acc_q == BOT));  // R7

endmodule

// File: rtl/dsm_sign_q.sv
module dsm_sign_q #(
    parameter int ACC_W = 20,
    parameter int FB_W  = 2
) (
    input  logic signed [ACC_W-1:0] val,
    output logic signed [FB_W-1:0]  lvl
);

    assign lvl = (val > 0) ? FB_W'(1) : {FB_W{1'b1}};

endmodule

// File: rtl/dsm_round_q.sv
module dsm_round_q #(
    parameter int ACC_W = 20,
    parameter int FB_W  = 4,
    parameter int SHIFT = 12,
    parameter int QBITS = 4
) (
    input  logic signed [ACC_W-1:0] val,
    output logic signed [FB_W-1:0]  lvl
);

    localparam int SW   = ACC_W + 1;
    localparam int LMAX = (2 ** (QBITS - 1)) - 1;
    localparam int LMIN = -(2 ** (QBITS - 1));
    localparam logic signed [SW-1:0] HALF = SW'(1) <<< (SHIFT - 1);

    logic signed [SW-1:0] tmp;
    logic signed [SW-1:0] rnd;

    assign tmp = SW'(val) + HALF;
    assign rnd = tmp >>> SHIFT;

    always_comb begin
        if (rnd > SW'(LMAX))      lvl = FB_W'(LMAX);
        else if (rnd < SW'(LMIN)) lvl = FB_W'(LMIN);
        else                      lvl = FB_W'(rnd);
    end

endmodule

// File: rtl/dsm_modulator.sv
module dsm_modulator #(
    parameter int SAMPLE_W = 16,
    parameter int ORDER    = 2,
    parameter int QBITS    = 4,
    parameter int HEADROOM = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_vld,
    input  logic signed [SAMPLE_W-1:0] smp_in,
    output logic [QBITS-1:0]           dac_code
);

    localparam int ACC_W  = SAMPLE_W + HEADROOM;
    localparam int DW     = ACC_W + 2;
    localparam int SHIFT  = SAMPLE_W - QBITS;
    localparam int FB_W   = (QBITS == 1) ? 2 : QBITS;
    localparam int LMAX_T = (2 ** (QBITS - 1)) - 1;
    localparam int LMIN_T = -(2 ** (QBITS - 1));

    logic signed [SAMPLE_W-1:0] held;
    logic signed [FB_W-1:0]     fb_q;
    logic signed [FB_W-1:0]     lvl_nx;
    logic signed [DW-1:0]       fb_scaled;
    logic signed [DW-1:0]       d1;
    logic signed [ACC_W-1:0]    a1_nx;
    logic signed [ACC_W-1:0]    fin_nx;

    dsm_hold #(.W(SAMPLE_W)) u_hold (
        .clk (clk),
        .rst (rst),
        .vld (smp_vld),
        .din (smp_in),
        .held(held)
    );

    // feedback level scaled to input units
    assign fb_scaled = DW'(fb_q) <<< SHIFT;
    assign d1        = DW'(held) - fb_scaled;

    dsm_integ #(.ACC_W(ACC_W), .DW(DW)) u_int1 (
        .clk   (clk),
        .rst   (rst),
        .delta (d1),
        .acc_nx(a1_nx)
    );

    generate
        if (ORDER == 1) begin : g_ord1
            assign fin_nx = a1_nx;
        end else begin : g_ord2
            logic signed [DW-1:0] d2;
            assign d2 = DW'(a1_nx) - fb_scaled;
            dsm_integ #(.ACC_W(ACC_W), .DW(DW)) u_int2 (
                .clk   (clk),
                .rst   (rst),
                .delta (d2),
                .acc_nx(fin_nx)
            );
        end

        if (QBITS == 1) begin : g_sign
            dsm_sign_q #(.ACC_W(ACC_W), .FB_W(FB_W)) u_q (
                .val(fin_nx),
                .lvl(lvl_nx)
            );
            assign dac_code = QBITS'(fb_q > 0);

            AST_SIGN_POS: assert property (@(posedge clk) disable iff (rst)
                (fin_nx > 0) |=> (fb_q == FB_W'(1)));  // R3
            AST_SIGN_NEG: assert property (@(posedge clk) disable iff (rst)
                (fin_nx <= 0) |=> (fb_q == {FB_W{1'b1}}));  // R3
        end else begin : g_round
            dsm_round_q #(.ACC_W(ACC_W), .FB_W(FB_W), .SHIFT(SHIFT), .QBITS(QBITS)) u_q (
                .val(fin_nx),
                .lvl(lvl_nx)
            );
            assign dac_code = fb_q;

            AST_CLAMP_HI: assert property (@(posedge clk) disable iff (rst)
                (fin_nx >= ACC_W'(LMAX_T <<< SHIFT)) |=> (fb_q == FB_W'(LMAX_T)));  // R6
            AST_CLAMP_LO: assert property (@(posedge clk) disable iff (rst)
                (fin_nx <= ACC_W'(LMIN_T <<< SHIFT)) |=> (fb_q == FB_W'(LMIN_T)));  // R6
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) fb_q <= '0;
        else     fb_q <= lvl_nx;
    end

    AST_FB_CLEAR: assert property (@(posedge clk)
        rst |=> (fb_q == '0));  // R2

endmodule

// File: tb/dsm_modulator_tb_top.sv
module dsm_modulator_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst = 1'b1;
    logic               vld = 1'b0;
    logic signed [15:0] din = '0;
    logic [3:0]         code2;
    logic [0:0]         code1;

    dsm_modulator dut_i (
        .clk(clk), .rst(rst), .smp_vld(vld), .smp_in(din), .dac_code(code2)
    );
    dsm_modulator #(.ORDER(1), .QBITS(1)) dut1_i (
        .clk(clk), .rst(rst), .smp_vld(vld), .smp_in(din), .dac_code(code1)
    );

    integer n_chk = 0;
    integer n_bad = 0;

    // independent arithmetic model of both loops
    integer mh = 0, ma = 0, mb = 0, mq2 = 0, mc = 0, mq1 = 0;
    integer n1, n2, r, o1;

    function automatic integer sat20(input integer v);
        if (v > 524287)  return 524287;
        if (v < -524288) return -524288;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mh = 0; ma = 0; mb = 0; mq2 = 0; mc = 0; mq1 = 0;
        end else begin
            n1 = sat20(ma + mh - mq2 * 4096);
            n2 = sat20(mb + n1 - mq2 * 4096);
            r  = (n2 + 2048) >>> 12;
            if (r > 7)  r = 7;
            if (r < -8) r = -8;
            ma = n1; mb = n2; mq2 = r;
            o1 = sat20(mc + mh - mq1 * 32768);
            mc = o1;
            mq1 = (o1 > 0) ? 1 : -1;
            if (vld) mh = din;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input integer act, input integer exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    integer mis2, mis1, sum2, sum1, last2;

    task automatic run(input integer n, input bit scramble);
        mis2 = 0; mis1 = 0; sum2 = 0; sum1 = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            last2 = integer'($signed(code2));
            if (last2 != mq2) mis2++;
            if (integer'(code1) != ((mq1 > 0) ? 1 : 0)) mis1++;
            sum2 += last2;
            sum1 += (code1 == 1'b1) ? 1 : -1;
            if (scramble) din = 16'($urandom);
        end
    endtask

    task automatic load(input integer s);
        @(negedge clk);
        din = 16'(s);
        vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
    endtask

    function automatic integer iabs(input integer v);
        return (v < 0) ? -v : v;
    endfunction

    localparam int NVEC = 6;
    localparam int VEC [NVEC] = '{0, 8000, -8000, 16000, -20000, 3};

    initial begin
        // R2: outputs during reset
        repeat (3) @(negedge clk);
        check(code2 == 4'd0, "R2", "4-bit code in reset", integer'(code2), 0);
        check(code1 == 1'b0, "R2", "1-bit code in reset", integer'(code1), 0);
        rst = 1'b0;
        @(negedge clk);
        check(code1 == 1'b0, "R3", "first 1-bit code after reset", integer'(code1), 0);
        check(code2 == 4'd0, "R2", "4-bit code idle at zero", integer'(code2), 0);
        @(negedge clk);
        check(code1 == 1'b1, "R3", "second 1-bit code after reset", integer'(code1), 1);
        run(32, 1'b0);
        check(mis2 == 0 && sum2 == 0, "R2", "4-bit zeros after reset", mis2 + iabs(sum2), 0);

        // vector table: stream vs model and long-run mean
        for (int v = 0; v < NVEC; v++) begin
            load(VEC[v]);
            run(1024, 1'b0);
            check(mis2 == 0, "R4", "second-order stream mismatches", mis2, 0);
            check(mis2 == 0, "R5", "rounding stream mismatches", mis2, 0);
            check(mis1 == 0, "R3", "first-order stream mismatches", mis1, 0);
            check(iabs(sum2 * 4096 - 1024 * VEC[v]) <= 1024 * 128, "R8",
                  "4-bit mean*1024", sum2 * 4096, 1024 * VEC[v]);
            check(iabs(sum1 * 32768 - 1024 * VEC[v]) <= 1024 * 128, "R8",
                  "1-bit mean*1024", sum1 * 32768, 1024 * VEC[v]);
        end

        // R1: input ignored without strobe
        load(5000);
        run(1024, 1'b1);
        check(iabs(sum2 * 4096 - 1024 * 5000) <= 1024 * 128, "R1",
              "4-bit mean with toggling unstrobed input", sum2 * 4096, 1024 * 5000);
        check(iabs(sum1 * 32768 - 1024 * 5000) <= 1024 * 128, "R1",
              "1-bit mean with toggling unstrobed input", sum1 * 32768, 1024 * 5000);
        check(mis2 == 0 && mis1 == 0, "R1", "stream mismatches while holding", mis2 + mis1, 0);

        // R6/R7: overdrive, clamp, saturate, recover
        load(32767);
        run(400, 1'b0);
        check(last2 == 7, "R6", "top clamp level", last2, 7);
        check(mis2 == 0, "R7", "overdrive high stream", mis2, 0);
        load(-32768);
        run(400, 1'b0);
        check(last2 == -8, "R6", "bottom clamp level", last2, -8);
        check(mis2 == 0, "R7", "overdrive low stream", mis2, 0);
        load(0);
        run(600, 1'b0);
        check(mis2 == 0 && mis1 == 0, "R7", "recovery after saturation", mis2 + mis1, 0);

        // R2: mid-run reset
        load(12000);
        run(50, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(code2 == 4'd0 && code1 == 1'b0, "R2", "codes during mid-run reset",
              integer'(code2) + integer'(code1), 0);
        rst = 1'b0;
        run(64, 1'b0);
        check(mis2 == 0 && sum2 == 0, "R2", "held sample cleared by reset", iabs(sum2) + mis2, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule